// File: doc/BRIEF.md
# PCI Burst Read Initiator

This block is the bus-master half of a 32-bit PCI memory read burst. A DMA engine hands it a start address, a word count and a set of byte-lane enables. The block then runs one read transaction on the bus: an address phase carrying the memory read command, a turnaround clock, and one data phase per requested word. Each word the target supplies is returned to the engine as `rd_data_o` with a one-clock `rd_valid_o` strobe.

The engine throttles the burst with `sink_ready_i`. When it is low at the start of a data phase, the initiator leaves IRDY deasserted and inserts wait cycles. Once IRDY is asserted it stays asserted until that word moves. FRAME is released only in the same clock in which IRDY is asserted for the last word. If the engine is not ready when the last phase comes up, FRAME therefore stays asserted and IRDY stays deasserted until it is.

If no target claims the cycle with DEVSEL within a fixed number of clocks after the address phase, the block drops the bus and raises an error flag. Arbitration, parity and target-initiated termination are handled elsewhere. All bus outputs come from registers on the rising clock, and the AD and C/BE drivers have separate enables.

Top module: `pci_rd_burst_master`

## Requirements
- R1: After reset, FRAME# and IRDY# are high (deasserted), both output enables are low, and busy, done, err and rd_valid are all low.
- R2: A request with a nonzero word count, presented while idle, is accepted on a rising edge. From that edge on, FRAME# is low, AD carries the request address with its enable high, C/BE carries the memory read command 4'b0110 with its enable high, and busy is high. That clock is the address phase.
- R3: In the clock after the address phase the AD enable is low (turnaround). Through every data phase, C/BE carries the request byte enables with its enable high.
- R4: A word moves only on an edge where IRDY#, TRDY# and DEVSEL# are all sampled low. The word sampled on AD appears on rd_data with rd_valid high for exactly the following clock. Words are returned in bus order.
- R5: At the start of each data phase, including the first, IRDY# goes low only if sink_ready was high on the preceding edge; otherwise it stays high as a wait cycle. Once low, IRDY# stays low until a word moves.
- R6: FRAME# goes high only together with IRDY# going low for the last word. While the last phase waits on a not-ready sink, FRAME# stays low.
- R7: After the last word, FRAME# and IRDY# are high, both enables are low, busy is low, and done is high for exactly one clock.
- R8: If DEVSEL# is not sampled low on any of the 5 edges after the address phase, the bus is released on the 5th edge with done pulsed and err set. err holds until the next accepted request clears it.
- R9: A request with word count 0 is ignored, and a request presented while busy is ignored; in both cases the bus stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start request, taken when idle |
| req_addr_i | input | 32 | Burst start address |
| req_words_i | input | CNT_W | Number of words to read |
| req_be_i | input | 4 | Byte-lane enables for the data phases (active low on the bus) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock pulse when the transaction ends |
| err_o | output | 1 | DEVSEL timeout occurred in the last transaction |
| sink_ready_i | input | 1 | Engine can take the next word |
| rd_valid_o | output | 1 | Read word strobe |
| rd_data_o | output | 32 | Read word |
| frame_n_o | output | 1 | FRAME#, active low |
| irdy_n_o | output | 1 | IRDY#, active low |
| ad_o | output | 32 | AD output value |
| ad_oe_o | output | 1 | AD driver enable |
| cbe_o | output | 4 | C/BE# output value |
| cbe_oe_o | output | 1 | C/BE# driver enable |
| ad_i | input | 32 | AD as seen on the bus |
| trdy_n_i | input | 1 | TRDY#, active low |
| devsel_n_i | input | 1 | DEVSEL#, active low |

## Verification
The assertions take for granted a well-behaved target. It asserts TRDY# only while DEVSEL# is asserted, keeps DEVSEL# asserted once asserted for the rest of the transaction, and holds TRDY# low once asserted until IRDY# completes the phase. The IRDY hold check relies on this, and so does the rule that a read strobe follows only a completed phase. The bench target model builds its TRDY# pattern from a per-clock mask, gated by a monotone DEVSEL# that asserts at a chosen clock. It holds TRDY# across a pending phase and releases both signals only after the initiator has gone idle, so every stimulus stays inside these assumptions.

// File: rtl/pci_rdm_pkg.sv
package pci_rdm_pkg;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } rdm_state_e;

    typedef struct packed {
        logic        frame_n;
        logic        irdy_n;
        logic [31:0] ad;
        logic        ad_oe;
        logic [3:0]  cbe;
        logic        cbe_oe;
    } pci_bus_t;

    localparam pci_bus_t BUS_IDLE = '{
        frame_n: 1'b1,
        irdy_n:  1'b1,
        ad:      32'h0,
        ad_oe:   1'b0,
        cbe:     4'h0,
        cbe_oe:  1'b0
    };

endpackage

// File: rtl/pci_rdm_devsel_timer.sv
module pci_rdm_devsel_timer #(
    parameter int unsigned WAIT_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic devsel_n_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(WAIT_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CLKS - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = tmr_q.armed && devsel_n_i && (tmr_q.cnt == LAST);
        if (start_i) begin
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = '0;
        end else if (tmr_q.armed) begin
            if (!devsel_n_i || expire_o) begin
                tmr_d.armed = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pci_rdm_capture.sv
module pci_rdm_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_i,
    input  logic [31:0] ad_i,
    output logic        rd_valid_o,
    output logic [31:0] rd_data_o
);
    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = xfer_i;
        if (xfer_i) begin
            cap_d.data = ad_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_valid_o = cap_q.valid;
    assign rd_data_o  = cap_q.data;

endmodule

// File: rtl/pci_rdm_ctl.sv
module pci_rdm_ctl
    import pci_rdm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [31:0]      req_addr_i,
    input  logic [CNT_W-1:0] req_words_i,
    input  logic [3:0]       req_be_i,
    input  logic             sink_ready_i,
    input  logic             trdy_n_i,
    input  logic             devsel_n_i,
    input  logic             expire_i,
    output pci_bus_t         bus_o,
    output logic             xfer_o,
    output logic             start_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        rdm_state_e       st;
        pci_bus_t         bus;
        logic [CNT_W-1:0] rem;
        logic [3:0]       be;
        logic             done;
        logic             err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   ST_IDLE,
        bus:  BUS_IDLE,
        rem:  '0,
        be:   4'h0,
        done: 1'b0,
        err:  1'b0
    };

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        start_o    = 1'b0;
        xfer_o     = (ctl_q.st == ST_DATA) && !ctl_q.bus.irdy_n
                     && !trdy_n_i && !devsel_n_i;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid_i && (req_words_i != '0)) begin
                    start_o            = 1'b1;
                    ctl_d.st           = ST_ADDR;
                    ctl_d.bus.frame_n  = 1'b0;
                    ctl_d.bus.irdy_n   = 1'b1;
                    ctl_d.bus.ad       = req_addr_i;
                    ctl_d.bus.ad_oe    = 1'b1;
                    ctl_d.bus.cbe      = CMD_MEM_READ;
                    ctl_d.bus.cbe_oe   = 1'b1;
                    ctl_d.rem          = req_words_i;
                    ctl_d.be           = req_be_i;
                    ctl_d.err          = 1'b0;
                end
            end
            ST_ADDR: begin
                if (expire_i) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.bus  = BUS_IDLE;
                    ctl_d.err  = 1'b1;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.st          = ST_DATA;
                    ctl_d.bus.ad      = '0;
                    ctl_d.bus.ad_oe   = 1'b0;
                    ctl_d.bus.cbe     = ctl_q.be;
                    ctl_d.bus.irdy_n  = !sink_ready_i;
                    ctl_d.bus.frame_n = sink_ready_i && (ctl_q.rem == ONE);
                end
            end
            ST_DATA: begin
                if (expire_i) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.bus  = BUS_IDLE;
                    ctl_d.err  = 1'b1;
                    ctl_d.done = 1'b1;
                end else if (xfer_o) begin
                    ctl_d.rem = ctl_q.rem - 1'b1;
                    if (ctl_q.rem == ONE) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.bus  = BUS_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.bus.irdy_n  = !sink_ready_i;
                        ctl_d.bus.frame_n = sink_ready_i && (ctl_q.rem == TWO);
                    end
                end else if (ctl_q.bus.irdy_n) begin
                    ctl_d.bus.irdy_n  = !sink_ready_i;
                    ctl_d.bus.frame_n = sink_ready_i && (ctl_q.rem == ONE);
                end
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_o  = ctl_q.bus;
    assign busy_o = (ctl_q.st != ST_IDLE);
    assign done_o = ctl_q.done;
    assign err_o  = ctl_q.err;

endmodule

// File: rtl/pci_rd_burst_master.sv
module pci_rd_burst_master
    import pci_rdm_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned DEVSEL_WAIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [31:0]      req_addr_i,
    input  logic [CNT_W-1:0] req_words_i,
    input  logic [3:0]       req_be_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    input  logic             sink_ready_i,
    output logic             rd_valid_o,
    output logic [31:0]      rd_data_o,
    output logic             frame_n_o,
    output logic             irdy_n_o,
    output logic [31:0]      ad_o,
    output logic             ad_oe_o,
    output logic [3:0]       cbe_o,
    output logic             cbe_oe_o,
    input  logic [31:0]      ad_i,
    input  logic             trdy_n_i,
    input  logic             devsel_n_i
);
    pci_bus_t bus;
    logic     xfer;
    logic     start;
    logic     expire;

    pci_rdm_ctl #(
        .CNT_W (CNT_W)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_addr_i   (req_addr_i),
        .req_words_i  (req_words_i),
        .req_be_i     (req_be_i),
        .sink_ready_i (sink_ready_i),
        .trdy_n_i     (trdy_n_i),
        .devsel_n_i   (devsel_n_i),
        .expire_i     (expire),
        .bus_o        (bus),
        .xfer_o       (xfer),
        .start_o      (start),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    pci_rdm_devsel_timer #(
        .WAIT_CLKS (DEVSEL_WAIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .devsel_n_i (devsel_n_i),
        .expire_o   (expire)
    );

    pci_rdm_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_i     (xfer),
        .ad_i       (ad_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign frame_n_o = bus.frame_n;
    assign irdy_n_o  = bus.irdy_n;
    assign ad_o      = bus.ad;
    assign ad_oe_o   = bus.ad_oe;
    assign cbe_o     = bus.cbe;
    assign cbe_oe_o  = bus.cbe_oe;

endmodule

// File: rtl/pci_rd_burst_master_chk.sv
module pci_rd_burst_master_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [CNT_W-1:0] req_words_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic             rd_valid_o,
    input logic             frame_n_o,
    input logic             irdy_n_o,
    input logic             ad_oe_o,
    input logic [3:0]       cbe_o,
    input logic             cbe_oe_o,
    input logic             trdy_n_i,
    input logic             devsel_n_i
);
    a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> (ad_oe_o && cbe_oe_o && cbe_o == 4'b0110 && busy_o));

    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |=> !ad_oe_o);

    a_r4_valid_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(!irdy_n_o && !trdy_n_i && !devsel_n_i));

    a_r5_irdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n_o && trdy_n_i && !devsel_n_i) |=> !irdy_n_o);

    a_r6_frame_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_n_o) && !err_o) |-> !irdy_n_o);

    a_r7_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (frame_n_o && irdy_n_o && !ad_oe_o && !cbe_oe_o));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (done_o && !busy_o));

    a_r9_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid_i && req_words_i == '0) |=> !busy_o);

endmodule

bind pci_rd_burst_master pci_rd_burst_master_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_words_i (req_words_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rd_valid_o  (rd_valid_o),
    .frame_n_o   (frame_n_o),
    .irdy_n_o    (irdy_n_o),
    .ad_oe_o     (ad_oe_o),
    .cbe_o       (cbe_o),
    .cbe_oe_o    (cbe_oe_o),
    .trdy_n_i    (trdy_n_i),
    .devsel_n_i  (devsel_n_i)
);

// File: tb/pci_rd_burst_master_bench.sv
`timescale 1ns/1ps
module pci_rd_burst_master_bench;

    localparam int TO_CLKS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [7:0]  req_words_i = '0;
    logic [3:0]  req_be_i = '0;
    logic        busy_o, done_o, err_o;
    logic        sink_ready_i = 1'b0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic        frame_n_o, irdy_n_o;
    logic [31:0] ad_o;
    logic        ad_oe_o;
    logic [3:0]  cbe_o;
    logic        cbe_oe_o;
    logic [31:0] ad_i = '0;
    logic        trdy_n_i = 1'b1;
    logic        devsel_n_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pci_rd_burst_master u_pci_rd_burst_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_words_i(req_words_i), .req_be_i(req_be_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .sink_ready_i(sink_ready_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o), .cbe_o(cbe_o), .cbe_oe_o(cbe_oe_o),
        .ad_i(ad_i), .trdy_n_i(trdy_n_i), .devsel_n_i(devsel_n_i)
    );

    function automatic logic [31:0] word_of(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(frame_n_o == 1'b1, {tag, " frame_n"}, 32'(frame_n_o), 32'd1);
        chk(irdy_n_o == 1'b1, {tag, " irdy_n"}, 32'(irdy_n_o), 32'd1);
        chk(ad_oe_o == 1'b0, {tag, " ad_oe"}, 32'(ad_oe_o), 32'd0);
        chk(cbe_oe_o == 1'b0, {tag, " cbe_oe"}, 32'(cbe_oe_o), 32'd0);
        chk(busy_o == 1'b0, {tag, " busy"}, 32'(busy_o), 32'd0);
    endtask

    // R1: state right after reset
    task automatic t_reset;
        @(negedge clk);
        chk_idle("R1");
        chk(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
        chk(err_o == 1'b0, "R1 err", 32'(err_o), 32'd0);
        chk(rd_valid_o == 1'b0, "R1 rd_valid", 32'(rd_valid_o), 32'd0);
    endtask

    // One burst with a target whose DEVSEL asserts at clock dlat after the
    // address phase and whose TRDY follows tmask; sink readiness follows smask.
    task automatic run_burst(input logic [31:0] addr, input int words,
                             input logic [3:0] be, input int dlat,
                             input logic [15:0] tmask, input logic [15:0] smask,
                             input bit poke);
        int  rem = words;
        int  widx = 0;
        int  k = 1;
        bit  sink_r, trdy_r, devsel_r, irdy_prev, frame_prev, seen, fin, xferp;
        bit  ei, ef;
        @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = addr; req_words_i = 8'(words); req_be_i = be;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(frame_n_o == 1'b0, "R2 frame_n", 32'(frame_n_o), 32'd0);
        chk(ad_o == addr && ad_oe_o, "R2 address", ad_o, addr);
        chk(cbe_o == 4'b0110 && cbe_oe_o, "R2 command", 32'(cbe_o), 32'h6);
        chk(busy_o == 1'b1, "R2 busy", 32'(busy_o), 32'd1);
        chk(err_o == 1'b0, "R8 err cleared on accept", 32'(err_o), 32'd0);
        seen = 1'b0; fin = 1'b0;
        irdy_prev = irdy_n_o; frame_prev = frame_n_o;
        sink_r = smask[k % 16];
        devsel_r = !(k >= dlat);
        trdy_r = !(!devsel_r && tmask[k % 16]);
        sink_ready_i = sink_r; devsel_n_i = devsel_r; trdy_n_i = trdy_r;
        ad_i = word_of(widx);
        for (int it = 0; it < 300 && !fin; it++) begin
            @(negedge clk);
            k++;
            xferp = !irdy_prev && !trdy_r && !devsel_r;
            if (!devsel_r) seen = 1'b1;
            if (!seen && (k - 1) == TO_CLKS) begin
                chk_idle("R8 abort");
                chk(err_o == 1'b1, "R8 err", 32'(err_o), 32'd1);
                chk(done_o == 1'b1, "R8 done", 32'(done_o), 32'd1);
                fin = 1'b1;
            end else begin
                if (xferp) begin
                    chk(rd_valid_o == 1'b1, "R4 rd_valid", 32'(rd_valid_o), 32'd1);
                    chk(rd_data_o == word_of(widx), "R4 rd_data", rd_data_o, word_of(widx));
                    widx++; rem--;
                end else begin
                    chk(rd_valid_o == 1'b0, "R4 no strobe", 32'(rd_valid_o), 32'd0);
                end
                if (xferp && rem == 0) begin
                    chk_idle("R7 end");
                    chk(done_o == 1'b1, "R7 done", 32'(done_o), 32'd1);
                    chk(err_o == 1'b0, "R7 err", 32'(err_o), 32'd0);
                    fin = 1'b1;
                end else begin
                    if (xferp || irdy_prev) begin
                        ei = !sink_r; ef = sink_r && rem == 1;
                    end else begin
                        ei = 1'b0; ef = frame_prev;
                    end
                    chk(irdy_n_o == ei, "R5 irdy_n", 32'(irdy_n_o), 32'(ei));
                    chk(frame_n_o == ef, "R6 frame_n", 32'(frame_n_o), 32'(ef));
                    chk(ad_oe_o == 1'b0, "R3 ad_oe", 32'(ad_oe_o), 32'd0);
                    chk(cbe_o == be && cbe_oe_o, "R3 byte enables", 32'(cbe_o), 32'(be));
                    chk(busy_o && !done_o, "R9 busy held", 32'({busy_o, done_o}), 32'd2);
                end
            end
            if (!fin) begin
                irdy_prev = irdy_n_o; frame_prev = frame_n_o;
                devsel_r = !(k >= dlat);
                if (!(!trdy_r && !xferp)) trdy_r = !(!devsel_r && tmask[k % 16]);
                sink_r = smask[k % 16];
                sink_ready_i = sink_r; devsel_n_i = devsel_r; trdy_n_i = trdy_r;
                ad_i = word_of(widx);
                if (poke && k == 3) begin
                    req_valid_i = 1'b1; req_addr_i = ~addr; req_words_i = 8'd2;
                end else begin
                    req_valid_i = 1'b0;
                end
            end
        end
        if (!fin) chk(1'b0, "R7 burst watchdog", 32'(widx), 32'(words));
        req_valid_i = 1'b0; devsel_n_i = 1'b1; trdy_n_i = 1'b1; sink_ready_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one clock", 32'(done_o), 32'd0);
        chk_idle("R9 stays idle");
    endtask

    // R9: zero word count leaves the bus idle
    task automatic t_zero_count;
        @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = 32'hDEAD_0000; req_words_i = 8'd0; req_be_i = 4'h0;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk_idle("R9 zero count");
        @(negedge clk);
        chk_idle("R9 zero count later");
    endtask

    // R8: err remains set while idle
    task automatic t_err_hold;
        repeat (3) @(negedge clk);
        chk(err_o == 1'b1, "R8 err held", 32'(err_o), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL global watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_burst(32'h1000_0040, 4, 4'h0, 1, 16'hFFFF, 16'hFFFF, 1'b0);
        run_burst(32'h2000_0100, 5, 4'h3, 2, 16'hAAAA, 16'hFFFF, 1'b0);
        run_burst(32'h3000_0200, 3, 4'h5, 1, 16'hFFFF, 16'h6666, 1'b0);
        run_burst(32'h3800_0000, 1, 4'hC, 1, 16'hFFFF, 16'hFFF0, 1'b0);
        run_burst(32'h4000_0300, 6, 4'hA, 3, 16'hB6DB, 16'hD5B7, 1'b1);
        run_burst(32'h5000_0000, 2, 4'h0, 5, 16'hFFFF, 16'hFFFF, 1'b0);
        run_burst(32'h6000_0000, 3, 4'h0, 6, 16'hFFFF, 16'hFFFF, 1'b0);
        t_err_hold();
        run_burst(32'h7000_0000, 2, 4'h1, 1, 16'hFFFF, 16'hFFFF, 1'b0);
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule